// File: doc/BRIEF.md
# Command-Response Buffer Control Register File

This block is the host-facing register window of a trusted-module command interface that serves only locality zero. A host reaches it through a simple single-cycle bus with byte, halfword and word accesses in little-endian order. The window is 128 bytes. Reads return the addressed bytes of a register image. Writes either store a value, for the interrupt enable word, or act as commands on the handshake state. The handshake state covers the idle and ready request, the locality grant, command start, command cancel and a sticky fatal error.

A backend engine does the command work. It receives a one-cycle start pulse with a command length, and a one-cycle cancel pulse. It returns a one-cycle completion pulse with an error flag. The length sent on start is the length field of the command header, which the buffer logic supplies on `cmd_hdr_len`, clipped to the buffer size. The window also exposes constant capability and identity fields, plus the size and address of the shared command and response buffer. That buffer sits directly after the window within one page.

Top module: `cmdbuf_ctrl_regs`

## Requirements
- R1: After reset, these all read zero: locality state (0x00), locality status (0x0C), control status (0x44) and start (0x4C). No start or cancel pulse is issued. Command size (0x58) and response size (0x64) read PAGE_SIZE-128, which is 0xF80 by default. Command address low/high (0x5C/0x60) and response address low/high (0x68/0x6C) read BASE_ADDR+0x80.
- R2: The interface identity reads as follows. The low word (0x30) is 0x01025811. Its fields are: type 1 in [3:0], version 1 in [7:4], locality-0-only 0 in [8], fast idle 0 in [9], transfer size code 3 in [12:11], FIFO 0 in [13], CRB 1 in [14], selector 1 in [18:17], unlocked 0 in [19], revision 1 in [31:24]. The high word (0x34) is {device 16'h0001, VENDOR_ID}.
- R3: A read of size 0 (byte), 1 (halfword) or 2 (word) at an aligned address returns the addressed bytes right-aligned in little-endian order. Reserved bytes and command-only registers read zero.
- R4: A write of value 1 to start (0x4C) while start bit 0 is clear does two things. It sets that bit, and one cycle later it issues exactly one start pulse. While the bit is already set, such a write issues no pulse.
- R5: A write of value 1 to cancel (0x48) issues one cancel pulse while start bit 0 is set, and none otherwise.
- R6: A completion pulse clears start bit 0. A completion with the error flag set also sets control status bit 0, which then stays set until reset.
- R7: A write to control request (0x40) acts as follows. Value 1 clears control status bit 1 (idle). Value 2 sets it. Any other value leaves it unchanged.
- R8: A write of value 1 to locality control (0x08) does four things. It sets locality status bit 0 (granted), clears status bit 1 (seized), and sets locality state bits 1 (assigned) and 7 (register valid). Values 2 and 8 change nothing.
- R9: Interrupt enable (0x50) stores written bytes per byte lane and keeps the last written value.
- R10: The length sent with a start pulse is min(cmd_hdr_len, PAGE_SIZE-128).
- R11: Writes to read-only registers and reserved bytes leave every readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset in the window, naturally aligned for the size |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write value, right-aligned |
| bus_rdata | output | 32 | Read value, right-aligned, combinational from address and size |
| cmd_hdr_len | input | LEN_W | Length field of the command header held in the buffer |
| be_start | output | 1 | One-cycle command start pulse |
| be_len | output | LEN_W | Command length, valid with be_start |
| be_cancel | output | 1 | One-cycle cancel pulse |
| be_done | input | 1 | One-cycle completion pulse |
| be_err | input | 1 | Completion carried an error, valid with be_done |

## Verification
The bench targets the start handshake at its edges. It repeats a start while a command runs, where a design that forgets the in-flight bit would send a second start. It sends a cancel after completion, where a design that stops checking the bit would issue a cancel to an idle backend. It also sends a long header, where a missing clip would hand the backend a length past the buffer. Non-code values written to the request and locality registers would flip idle or grant in a design that decodes single bits rather than whole values. Writes to size, identity and reserved words would corrupt readback in a design that stores every write. Byte and halfword reads at odd lanes expose a wrong lane shift. Errors followed by clean completions show whether the fatal bit is truly sticky.

// File: rtl/cmdbuf_pkg.sv
// Shared constants and types of the command-response buffer control window.
// Assumes a 32-bit host data path and a 128-byte window.
package cmdbuf_pkg;
    localparam int unsigned WIN_BYTES = 128;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned NUM_WORDS = WIN_BYTES / WORD_BYTES;
    localparam int unsigned WIN_AW = $clog2(WIN_BYTES);
    localparam int unsigned WORD_AW = $clog2(NUM_WORDS);

    // Register offsets; the host software contract depends on these
    localparam logic [6:0] OFS_LOC_STATE = 7'h00;
    localparam logic [6:0] OFS_LOC_CTRL  = 7'h08;
    localparam logic [6:0] OFS_LOC_STS   = 7'h0C;
    localparam logic [6:0] OFS_IFID_LO   = 7'h30;
    localparam logic [6:0] OFS_IFID_HI   = 7'h34;
    localparam logic [6:0] OFS_EXT_LO    = 7'h38;
    localparam logic [6:0] OFS_EXT_HI    = 7'h3C;
    localparam logic [6:0] OFS_REQ       = 7'h40;
    localparam logic [6:0] OFS_STS       = 7'h44;
    localparam logic [6:0] OFS_CANCEL    = 7'h48;
    localparam logic [6:0] OFS_START     = 7'h4C;
    localparam logic [6:0] OFS_IE        = 7'h50;
    localparam logic [6:0] OFS_IS        = 7'h54;
    localparam logic [6:0] OFS_CMD_SIZE  = 7'h58;
    localparam logic [6:0] OFS_CMD_LO    = 7'h5C;
    localparam logic [6:0] OFS_CMD_HI    = 7'h60;
    localparam logic [6:0] OFS_RSP_SIZE  = 7'h64;
    localparam logic [6:0] OFS_RSP_LO    = 7'h68;
    localparam logic [6:0] OFS_RSP_HI    = 7'h6C;

    // Whole-value command codes
    localparam logic [31:0] CODE_READY   = 32'd1;
    localparam logic [31:0] CODE_IDLE    = 32'd2;
    localparam logic [31:0] CODE_GO      = 32'd1;
    localparam logic [31:0] CODE_ABORT   = 32'd1;
    localparam logic [31:0] CODE_LOC_REQ = 32'd1;

    // Identity fields
    localparam logic [3:0] ID_TYPE     = 4'd1;
    localparam logic [3:0] ID_VERSION  = 4'd1;
    localparam logic [1:0] ID_XFER     = 2'd3;
    localparam logic       ID_CRB      = 1'b1;
    localparam logic [1:0] ID_SELECTOR = 2'd1;
    localparam logic [7:0] ID_REV      = 8'd1;
    localparam logic [15:0] ID_DEVICE  = 16'd1;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic ready;
        logic go_idle;
        logic start;
        logic cancel;
        logic loc_req;
    } cmd_strobe_t;
endpackage

// File: rtl/cmdbuf_bus_lanes.sv
// Byte-lane steering for the host bus: builds write byte enables and the
// lane-shifted write word, and extracts the addressed bytes on reads.
// Assumes accesses are naturally aligned; size 3 is treated as a word.
module cmdbuf_bus_lanes #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NB = DATA_W / 8,
    localparam int unsigned OFS_W = $clog2(NB)
) (
    input  logic [OFS_W-1:0]  byte_ofs,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic [NB-1:0]     byte_en,
    output logic [DATA_W-1:0] wvalue,
    output logic [DATA_W-1:0] wlane,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] val_mask;
    int unsigned span;

    // Value mask and byte count for the access size
    always_comb begin
        case (size)
            2'd0: begin
                val_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
                span = 1;
            end
            2'd1: begin
                val_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
                span = 2;
            end
            default: begin
                val_mask = '1;
                span = NB;
            end
        endcase
    end

    // Per-lane enable from offset and span
    for (genvar i = 0; i < NB; i++) begin : g_be
        assign byte_en[i] = (i >= int'(byte_ofs)) && (i < int'(byte_ofs) + int'(span));
    end

    // Write value and its lane-shifted form; read extraction
    always_comb begin
        wvalue = wdata & val_mask;
        wlane  = wvalue << {byte_ofs, 3'b000};
        rdata  = (rd_word >> {byte_ofs, 3'b000}) & val_mask;
    end
endmodule

// File: rtl/cmdbuf_cmd_decode.sv
// Decodes host writes to command registers into one-cycle strobes.
// A command fires only when the access hits the register offset exactly
// and the right-aligned value equals the whole code.
module cmdbuf_cmd_decode
    import cmdbuf_pkg::*;
(
    input  logic              wr_fire,
    input  logic [WIN_AW-1:0] addr,
    input  logic [31:0]       value,
    output cmd_strobe_t       strb
);
    // Offset and value match per command
    always_comb begin
        strb.ready   = wr_fire && (addr == OFS_REQ)      && (value == CODE_READY);
        strb.go_idle = wr_fire && (addr == OFS_REQ)      && (value == CODE_IDLE);
        strb.start   = wr_fire && (addr == OFS_START)    && (value == CODE_GO);
        strb.cancel  = wr_fire && (addr == OFS_CANCEL)   && (value == CODE_ABORT);
        strb.loc_req = wr_fire && (addr == OFS_LOC_CTRL) && (value == CODE_LOC_REQ);
    end
endmodule

// File: rtl/cmdbuf_ctrl_state.sv
// Holds the handshake state (run, fatal, idle, locality flags), the
// interrupt enable word, and drives the backend start and cancel pulses.
// Assumes be_done arrives only as a one-cycle pulse.
module cmdbuf_ctrl_state
    import cmdbuf_pkg::*;
#(
    parameter int unsigned LEN_W = 32,
    parameter int unsigned BUF_SIZE = 32'hF80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_strobe_t      strb,
    input  logic             done,
    input  logic             err,
    input  logic [3:0]       ie_we,
    input  logic [31:0]      ie_wlane,
    input  logic [LEN_W-1:0] hdr_len,
    output logic             running,
    output logic             fatal,
    output logic             idle,
    output logic             granted,
    output logic             seized,
    output logic             assigned,
    output logic             regvalid,
    output logic [31:0]      ie,
    output logic             be_start,
    output logic             be_cancel,
    output logic [LEN_W-1:0] be_len
);
    localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_SIZE);

    logic go;
    assign go = strb.start && !running;

    // Command-in-flight bit: set by an accepted start, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n)       running <= 1'b0;
        else if (go)      running <= 1'b1;
        else if (done)    running <= 1'b0;
    end

    // Backend pulses and clipped length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_start  <= 1'b0;
            be_cancel <= 1'b0;
            be_len    <= '0;
        end else begin
            be_start  <= go;
            be_cancel <= strb.cancel && running;
            if (go) be_len <= (hdr_len > BUF_LEN) ? BUF_LEN : hdr_len;
        end
    end

    // Sticky fatal error from a failed completion
    always_ff @(posedge clk) begin
        if (!rst_n)           fatal <= 1'b0;
        else if (done && err) fatal <= 1'b1;
    end

    // Idle flag driven by ready and go-idle requests
    always_ff @(posedge clk) begin
        if (!rst_n)              idle <= 1'b0;
        else if (strb.ready)     idle <= 1'b0;
        else if (strb.go_idle)   idle <= 1'b1;
    end

    // Locality zero grant flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted  <= 1'b0;
            seized   <= 1'b0;
            assigned <= 1'b0;
            regvalid <= 1'b0;
        end else if (strb.loc_req) begin
            granted  <= 1'b1;
            seized   <= 1'b0;
            assigned <= 1'b1;
            regvalid <= 1'b1;
        end
    end

    // Interrupt enable storage, one process per byte lane
    for (genvar b = 0; b < 4; b++) begin : g_ie
        always_ff @(posedge clk) begin
            if (!rst_n)        ie[8*b +: 8] <= 8'h00;
            else if (ie_we[b]) ie[8*b +: 8] <= ie_wlane[8*b +: 8];
        end
    end
endmodule

// File: rtl/cmdbuf_ctrl_regs.sv
// Top of the command-response buffer control window. Steers host byte lanes,
// decodes command writes, keeps handshake state and assembles the read image.
// Assumes naturally aligned host accesses and a single locality.
module cmdbuf_ctrl_regs
    import cmdbuf_pkg::*;
#(
    parameter logic [63:0] BASE_ADDR = 64'h0000_0000_FED4_0000,
    parameter int unsigned PAGE_SIZE = 4096,
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter int unsigned LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LEN_W-1:0]  cmd_hdr_len,
    output logic              be_start,
    output logic [LEN_W-1:0]  be_len,
    output logic              be_cancel,
    input  logic              be_done,
    input  logic              be_err
);
    localparam int unsigned BUF_SIZE = PAGE_SIZE - WIN_BYTES;
    localparam logic [63:0] BUF_ADDR = BASE_ADDR + 64'(WIN_BYTES);
    localparam logic [31:0] IFID_LO = {ID_REV, 4'b0, 1'b0, ID_SELECTOR, 2'b0,
                                       ID_CRB, 1'b0, ID_XFER, 1'b0, 1'b0, 1'b0,
                                       ID_VERSION, ID_TYPE};
    localparam logic [31:0] IFID_HI = {ID_DEVICE, VENDOR_ID};

    logic             wr_fire;
    logic [3:0]       byte_en;
    logic [31:0]      wvalue;
    logic [31:0]      wlane;
    logic [31:0]      rd_word;
    logic [3:0]       ie_we;
    cmd_strobe_t      strb;
    logic             running, fatal, idle, granted, seized, assigned, regvalid;
    logic [31:0]      ie;
    logic [31:0]      img [NUM_WORDS];

    assign wr_fire = bus_sel && bus_wr;

    cmdbuf_bus_lanes #(.DATA_W(32)) i_lanes (
        .byte_ofs (bus_addr[1:0]),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .rd_word  (rd_word),
        .byte_en  (byte_en),
        .wvalue   (wvalue),
        .wlane    (wlane),
        .rdata    (bus_rdata)
    );

    cmdbuf_cmd_decode i_decode (
        .wr_fire (wr_fire),
        .addr    (bus_addr),
        .value   (wvalue),
        .strb    (strb)
    );

    // Byte enables reach storage only for the interrupt enable word
    assign ie_we = (wr_fire && (bus_addr[WIN_AW-1:2] == OFS_IE[WIN_AW-1:2])) ? byte_en : 4'b0;

    cmdbuf_ctrl_state #(.LEN_W(LEN_W), .BUF_SIZE(BUF_SIZE)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .done      (be_done),
        .err       (be_err),
        .ie_we     (ie_we),
        .ie_wlane  (wlane),
        .hdr_len   (cmd_hdr_len),
        .running   (running),
        .fatal     (fatal),
        .idle      (idle),
        .granted   (granted),
        .seized    (seized),
        .assigned  (assigned),
        .regvalid  (regvalid),
        .ie        (ie),
        .be_start  (be_start),
        .be_cancel (be_cancel),
        .be_len    (be_len)
    );

    // Assemble the read image; unlisted words are reserved and read zero
    always_comb begin
        for (int w = 0; w < int'(NUM_WORDS); w++) img[w] = 32'h0;
        img[OFS_LOC_STATE[WIN_AW-1:2]] = {24'b0, regvalid, 5'b0, assigned, 1'b0};
        img[OFS_LOC_CTRL[WIN_AW-1:2]]  = 32'h0;
        img[OFS_LOC_STS[WIN_AW-1:2]]   = {30'b0, seized, granted};
        img[OFS_IFID_LO[WIN_AW-1:2]]   = IFID_LO;
        img[OFS_IFID_HI[WIN_AW-1:2]]   = IFID_HI;
        img[OFS_EXT_LO[WIN_AW-1:2]]    = 32'h0;
        img[OFS_EXT_HI[WIN_AW-1:2]]    = 32'h0;
        img[OFS_REQ[WIN_AW-1:2]]       = 32'h0;
        img[OFS_STS[WIN_AW-1:2]]       = {30'b0, idle, fatal};
        img[OFS_CANCEL[WIN_AW-1:2]]    = 32'h0;
        img[OFS_START[WIN_AW-1:2]]     = {31'b0, running};
        img[OFS_IE[WIN_AW-1:2]]        = ie;
        img[OFS_IS[WIN_AW-1:2]]        = 32'h0;
        img[OFS_CMD_SIZE[WIN_AW-1:2]]  = 32'(BUF_SIZE);
        img[OFS_CMD_LO[WIN_AW-1:2]]    = BUF_ADDR[31:0];
        img[OFS_CMD_HI[WIN_AW-1:2]]    = BUF_ADDR[63:32];
        img[OFS_RSP_SIZE[WIN_AW-1:2]]  = 32'(BUF_SIZE);
        img[OFS_RSP_LO[WIN_AW-1:2]]    = BUF_ADDR[31:0];
        img[OFS_RSP_HI[WIN_AW-1:2]]    = BUF_ADDR[63:32];
    end

    // Word select for the read path
    assign rd_word = img[bus_addr[WIN_AW-1:2]];
endmodule

// File: rtl/cmdbuf_ctrl_regs_chk.sv
// Protocol checker for the control window: backend pulse rules, completion
// handling, sticky fatal, length bound and idle cause. Bound to the top.
module cmdbuf_ctrl_regs_chk #(
    parameter int unsigned LEN_W = 32,
    parameter int unsigned BUF_SIZE = 32'hF80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             be_start,
    input logic             be_cancel,
    input logic [LEN_W-1:0] be_len,
    input logic             be_done,
    input logic             running,
    input logic             fatal,
    input logic             idle,
    input logic             go_idle_req
);
    AST_START_MARKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> running);  // R4
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start);  // R4
    AST_CANCEL_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |-> $past(running));  // R5
    AST_DONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (be_done && running) |=> !running);  // R6
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);  // R6
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> (be_len <= LEN_W'(BUF_SIZE)));  // R10
    AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(go_idle_req));  // R7
endmodule

bind cmdbuf_ctrl_regs cmdbuf_ctrl_regs_chk #(.LEN_W(LEN_W), .BUF_SIZE(BUF_SIZE)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .be_start    (be_start),
    .be_cancel   (be_cancel),
    .be_len      (be_len),
    .be_done     (be_done),
    .running     (running),
    .fatal       (fatal),
    .idle        (idle),
    .go_idle_req (strb.go_idle)
);

// File: tb/test_cmdbuf_ctrl_regs.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a register model kept in the bench.
module test_cmdbuf_ctrl_regs;
    import cmdbuf_pkg::*;

    localparam logic [63:0] BASE = 64'h0000_0001_FED4_0000;
    localparam logic [15:0] VID  = 16'h5A3C;
    localparam logic [31:0] BSZ  = 32'hF80;
    localparam logic [63:0] BUFA = BASE + 64'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [1:0] bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] cmd_hdr_len = '0, be_len;
    logic be_start, be_cancel;
    logic be_done = 1'b0, be_err = 1'b0;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic m_run = 0, m_fatal = 0, m_idle = 0, m_grant = 0, m_assigned = 0, m_valid = 0;
    logic [31:0] m_ie = '0;

    always #5 clk = ~clk;

    cmdbuf_ctrl_regs #(.BASE_ADDR(BASE), .PAGE_SIZE(4096), .VENDOR_ID(VID), .LEN_W(32)) i_cmdbuf_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_hdr_len(cmd_hdr_len), .be_start(be_start), .be_len(be_len),
        .be_cancel(be_cancel), .be_done(be_done), .be_err(be_err)
    );

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0: return 32'hFF;
            2'd1: return 32'hFFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input logic [4:0] w);
        case ({w, 2'b00})
            7'h00: return {24'b0, m_valid, 5'b0, m_assigned, 1'b0};
            7'h0C: return {31'b0, m_grant};
            7'h30: return 32'h0102_5811;
            7'h34: return {16'h0001, VID};
            7'h44: return {30'b0, m_idle, m_fatal};
            7'h4C: return {31'b0, m_run};
            7'h50: return m_ie;
            7'h58, 7'h64: return BSZ;
            7'h5C, 7'h68: return BUFA[31:0];
            7'h60, 7'h6C: return BUFA[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [6:0] a, input logic [1:0] sz);
        return (exp_word(a[6:2]) >> {a[1:0], 3'b000}) & size_mask(sz);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [6:0] a, input logic [1:0] sz, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        check(req, bus_rdata, exp_read(a, sz));
        bus_sel = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [1:0] sz, input logic [31:0] d,
                            input logic [31:0] hl);
        logic [31:0] v;
        logic e_start, e_cancel;
        v = d & size_mask(sz);
        e_start  = (a == 7'h4C) && (v == 32'd1) && !m_run;
        e_cancel = (a == 7'h48) && (v == 32'd1) && m_run;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        cmd_hdr_len = hl;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R4 start pulse", {31'b0, be_start}, {31'b0, e_start});
        check("R5 cancel pulse", {31'b0, be_cancel}, {31'b0, e_cancel});
        if (e_start) check("R10 length", be_len, (hl > BSZ) ? BSZ : hl);
        // Model update
        if (a == 7'h40 && v == 32'd1) m_idle = 1'b0;
        if (a == 7'h40 && v == 32'd2) m_idle = 1'b1;
        if (e_start) m_run = 1'b1;
        if (a == 7'h08 && v == 32'd1) begin
            m_grant = 1'b1; m_assigned = 1'b1; m_valid = 1'b1;
        end
        if (a[6:2] == 5'h14) begin
            for (int b = 0; b < 4; b++)
                if (b >= int'(a[1:0]) && b < int'(a[1:0]) + (sz == 0 ? 1 : sz == 1 ? 2 : 4))
                    m_ie[8*b +: 8] = v[8*(b - int'(a[1:0])) +: 8];
        end
    endtask

    task automatic complete(input logic e);
        @(negedge clk);
        be_done = 1'b1; be_err = e;
        @(negedge clk);
        be_done = 1'b0; be_err = 1'b0;
        m_run = 1'b0;
        if (e) m_fatal = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 no start", {31'b0, be_start}, 32'h0);
        check("R1 no cancel", {31'b0, be_cancel}, 32'h0);
        do_read(7'h00, 2, "R1 loc state");
        do_read(7'h0C, 2, "R1 loc status");
        do_read(7'h44, 2, "R1 ctrl status");
        do_read(7'h4C, 2, "R1 start");
        do_read(7'h58, 2, "R1 cmd size");
        do_read(7'h5C, 2, "R1 cmd addr lo");
        do_read(7'h60, 2, "R1 cmd addr hi");
        do_read(7'h64, 2, "R1 rsp size");
        do_read(7'h68, 2, "R1 rsp addr lo");
        do_read(7'h6C, 2, "R1 rsp addr hi");
        // R2 identity
        do_read(7'h30, 2, "R2 id lo");
        do_read(7'h34, 2, "R2 id hi");
        // R3 narrow reads and reserved
        do_read(7'h31, 0, "R3 byte lane1");
        do_read(7'h32, 1, "R3 half upper");
        do_read(7'h36, 1, "R3 half device");
        do_read(7'h20, 2, "R3 reserved");
        do_read(7'h7C, 2, "R3 reserved tail");
        // R7 idle request
        do_write(7'h40, 2, 32'd2, 0); do_read(7'h44, 2, "R7 go idle");
        do_write(7'h40, 2, 32'd3, 0); do_read(7'h44, 2, "R7 other value");
        do_write(7'h40, 2, 32'd1, 0); do_read(7'h44, 2, "R7 ready");
        // R8 locality
        do_write(7'h08, 2, 32'd2, 0); do_read(7'h0C, 2, "R8 relinquish");
        do_write(7'h08, 2, 32'd8, 0); do_read(7'h00, 2, "R8 reset establishment");
        do_write(7'h08, 0, 32'd1, 0); do_read(7'h0C, 2, "R8 granted");
        do_read(7'h00, 2, "R8 state");
        // R4 R5 R6 R10 handshake
        do_write(7'h48, 2, 32'd1, 0);  // cancel while idle: no pulse
        do_write(7'h4C, 2, 32'd1, 32'h40); do_read(7'h4C, 2, "R4 start set");
        do_write(7'h4C, 2, 32'd1, 32'h80);  // repeat while running: no pulse
        do_write(7'h48, 2, 32'd1, 0);  // cancel while running: pulse
        complete(1'b0); do_read(7'h4C, 2, "R6 cleared"); do_read(7'h44, 2, "R6 no fatal");
        do_write(7'h48, 2, 32'd1, 0);  // cancel after completion: no pulse
        do_write(7'h4C, 1, 32'd1, 32'h5000);  // clipped length
        complete(1'b1); do_read(7'h44, 2, "R6 fatal");
        do_write(7'h4C, 2, 32'd1, 32'hF80);
        complete(1'b0); do_read(7'h44, 2, "R6 fatal sticky");
        // R11 read-only and reserved writes
        do_write(7'h58, 2, 32'hFFFF_FFFF, 0); do_read(7'h58, 2, "R11 cmd size");
        do_write(7'h20, 2, 32'hFFFF_FFFF, 0); do_read(7'h20, 2, "R11 reserved");
        do_write(7'h30, 2, 32'h0, 0); do_read(7'h30, 2, "R11 id");
        do_write(7'h54, 2, 32'hFFFF_FFFF, 0); do_read(7'h54, 2, "R11 int status");
        // R9 interrupt enable lanes
        do_write(7'h50, 2, 32'hDEAD_BEEF, 0); do_read(7'h50, 2, "R9 word");
        do_write(7'h52, 0, 32'h0000_0055, 0); do_read(7'h50, 2, "R9 byte");
        do_write(7'h52, 1, 32'h0000_1234, 0); do_read(7'h52, 1, "R9 half");
        // Random traffic
        for (int n = 0; n < 800; n++) begin
            int op;
            logic [6:0] a;
            logic [1:0] sz;
            logic [31:0] d;
            op = int'($urandom % 10);
            sz = 2'($urandom % 3);
            if ($urandom % 2 == 0) begin
                case ($urandom % 8)
                    0: a = 7'h08; 1: a = 7'h40; 2: a = 7'h48; 3: a = 7'h4C;
                    4: a = 7'h50; 5: a = 7'h51; 6: a = 7'h58; default: a = 7'h30;
                endcase
            end else a = 7'($urandom % 128);
            if (sz == 1) a[0] = 1'b0;
            if (sz == 2) a[1:0] = 2'b00;
            d = ($urandom % 2 == 0) ? 32'($urandom % 4) : $urandom;
            if (op < 5) do_write(a, sz, d, 32'($urandom % 32'h2000));
            else if (op < 9) do_read(a, sz, "R3 random read");
            else complete(($urandom % 4) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule